// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block decides, one instruction at a time, which address a 32-bit RISC core fetches next. The core uses one branch delay slot. Each instruction arrives on a valid/ready stream together with its own address, and the block answers on a matching output beat. The answer carries the next fetch address and a flag that squashes the delay slot. For calls, the block also drives a one-cycle register-file write of the return address. The block also has a register read port, used by the register-indirect branch, and a condition-code input, used by the conditional branches.

A control transfer does not redirect at once. The beat that carries the branch points at the next sequential word, which is the delay slot. The beat that carries the delay slot then points at the branch target, if the branch was taken. A control transfer that sits in a delay slot behaves as an ordinary instruction.

The input and output streams move in lockstep and hold no buffer. `in_ready` is `out_ready`, and `out_valid` is `in_valid`. A beat is consumed only on the cycle where `in_valid` and `out_ready` are both high. While `out_ready` is low, no state changes and the source must hold its beat.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, `fetch_addr` equals the parameter `START_ADDR` and no delay slot is pending. After release, the first beat is treated as outside a delay slot.
- R2: A beat outside a delay slot whose opcode (bits 31:26) is not a control transfer yields `out_npc = in_pc + 4`, with `out_annul` low and `rf_we` low.
- R3: For a direct transfer, the target is `in_pc + 4 + (sign-extended bits 25:0) * 4`. The branch beat itself yields `in_pc + 4`. The next accepted beat (the delay slot) yields the target.
- R4: Opcode 0x1A is always taken. Opcode 0x1B is always taken and, on its accepted beat, drives `rf_we` high with `rf_idx = 1` and `rf_data = in_pc + 8`.
- R5: Opcodes 0x1C and 0x1D are taken when `cc_flag` is 1. Opcodes 0x1E and 0x1F are taken when `cc_flag` is 0. The flag is sampled on the branch beat. When the branch is not taken, the delay-slot beat yields its own `in_pc + 4`.
- R6: `out_annul` is high on a branch beat only for opcodes 0x1D and 0x1F when they are not taken. It is never high for the other opcodes.
- R7: Opcode 0x10 takes its target from the register whose index is in bits 15:11. That index is driven on `rd_idx` and `rd_data` is used in the same cycle. The target has bits 1:0 cleared.
- R8: A control transfer that arrives in a delay slot is treated as a plain instruction. It does not redirect, does not write a register, and does not annul.
- R9: `in_ready` follows `out_ready` and `out_valid` follows `in_valid`. A beat offered while `out_ready` is low changes no state.
- R10: After each accepted beat, `fetch_addr` holds that beat's `out_npc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction beat offered |
| in_ready | output | 1 | Instruction beat can be taken |
| in_pc | input | 32 | Address of the offered instruction |
| in_insn | input | 32 | Instruction word |
| cc_flag | input | 1 | Condition code |
| rd_idx | output | 5 | Register read index (bits 15:11 of the word) |
| rd_data | input | 32 | Register read data for `rd_idx`, same cycle |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result beat |
| out_npc | output | 32 | Address to fetch after this instruction |
| out_annul | output | 1 | Squash the following delay-slot instruction |
| rf_we | output | 1 | Return-address write enable |
| rf_idx | output | 5 | Return-address register index |
| rf_data | output | 32 | Return address |
| fetch_addr | output | 32 | Registered next fetch address |

## Verification
A wrong pending-slot flag shows on the very next accepted beat. One of two things happens: a delay slot yields its own successor instead of the target, or a branch placed in a delay slot redirects a second time. A corrupted pending target shows only on the delay-slot beat's `out_npc`, exactly one accepted beat after the branch. A stuck flag or a lost target can stay hidden until a taken branch is followed by a different address pattern. For that reason the random stimulus mixes many branches and stall cycles, and it compares every beat's `out_npc` and the registered `fetch_addr` on the following cycle.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    K_SEQ,
    K_JMP,
    K_CALL,
    K_BSET,
    K_BSETH,
    K_BCLR,
    K_BCLRH,
    K_IND
  } xfer_e;

  localparam logic [5:0] OP_IND   = 6'h10;
  localparam logic [5:0] OP_JMP   = 6'h1A;
  localparam logic [5:0] OP_CALL  = 6'h1B;
  localparam logic [5:0] OP_BSET  = 6'h1C;
  localparam logic [5:0] OP_BSETH = 6'h1D;
  localparam logic [5:0] OP_BCLR  = 6'h1E;
  localparam logic [5:0] OP_BCLRH = 6'h1F;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 26,
  parameter int RIDX_W = 5,
  parameter int RIDX_LSB = 11
) (
  input  logic [XLEN-1:0]   insn,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   rd_data,
  output xfer_e             kind,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]   tgt
);
  localparam int OP_W  = 6;
  localparam int EXT_W = XLEN - DISP_W - 2;

  logic [OP_W-1:0] op;
  logic [XLEN-1:0] disp_ext;
  logic [XLEN-1:0] pc_seq;

  assign op       = insn[XLEN-1 -: OP_W];
  assign rd_idx   = insn[RIDX_LSB +: RIDX_W];
  assign disp_ext = {{EXT_W{insn[DISP_W-1]}}, insn[DISP_W-1:0], 2'b00};
  assign pc_seq   = pc + XLEN'(4);

  always_comb begin
    unique case (op)
      OP_IND:   kind = K_IND;
      OP_JMP:   kind = K_JMP;
      OP_CALL:  kind = K_CALL;
      OP_BSET:  kind = K_BSET;
      OP_BSETH: kind = K_BSETH;
      OP_BCLR:  kind = K_BCLR;
      OP_BCLRH: kind = K_BCLRH;
      default:  kind = K_SEQ;
    endcase
  end

  always_comb begin
    if (kind == K_IND) tgt = rd_data & ~XLEN'(3);
    else               tgt = pc_seq + disp_ext;
  end
endmodule

// File: rtl/npc_resolve.sv
module npc_resolve
  import npc_pkg::*;
(
  input  xfer_e kind,
  input  logic  cc,
  output logic  is_xfer,
  output logic  is_call,
  output logic  take,
  output logic  hinted,
  output logic  annul
);
  always_comb begin
    unique case (kind)
      K_JMP, K_CALL, K_IND: take = 1'b1;
      K_BSET, K_BSETH:      take = cc;
      K_BCLR, K_BCLRH:      take = ~cc;
      default:              take = 1'b0;
    endcase
  end

  assign is_xfer = (kind != K_SEQ);
  assign is_call = (kind == K_CALL);
  assign hinted  = (kind == K_BSETH) || (kind == K_BCLRH);
  assign annul   = hinted && !take;
endmodule

// File: rtl/npc_seq.sv
module npc_seq #(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] START_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [XLEN-1:0] pc,
  input  logic            is_xfer,
  input  logic            take,
  input  logic [XLEN-1:0] tgt,
  output logic [XLEN-1:0] npc,
  output logic            slot_q,
  output logic [XLEN-1:0] pend_tgt,
  output logic [XLEN-1:0] fetch_q
);
  logic            take_q;
  logic [XLEN-1:0] tgt_q;
  logic            arm;

  assign arm      = !slot_q && is_xfer;
  assign npc      = (slot_q && take_q) ? tgt_q : pc + XLEN'(4);
  assign pend_tgt = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= 1'b0;
      take_q  <= 1'b0;
      tgt_q   <= '0;
      fetch_q <= START_ADDR;
    end else if (fire) begin
      slot_q  <= arm;
      take_q  <= arm && take;
      if (arm) tgt_q <= tgt;
      fetch_q <= npc;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (fetch_q == START_ADDR && !slot_q && !take_q));

  p_fetch_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> fetch_q == $past(npc));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(fetch_q) && $stable(slot_q) && $stable(tgt_q)));

  p_slot_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && slot_q) |=> !slot_q);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter int          DISP_W     = 26,
  parameter int          RIDX_W     = 5,
  parameter int          LINK_REG   = 1,
  parameter logic [31:0] START_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [XLEN-1:0]   in_insn,
  input  logic              cc_flag,
  output logic [RIDX_W-1:0] rd_idx,
  input  logic [XLEN-1:0]   rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_npc,
  output logic              out_annul,
  output logic              rf_we,
  output logic [RIDX_W-1:0] rf_idx,
  output logic [XLEN-1:0]   rf_data,
  output logic [XLEN-1:0]   fetch_addr
);
  xfer_e           kind;
  logic [XLEN-1:0] tgt;
  logic            is_xfer, is_call, take, hinted, annul;
  logic            fire, slot_q;
  logic [XLEN-1:0] pend_tgt;

  assign fire      = in_valid && out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;

  npc_decode #(
    .XLEN(XLEN), .DISP_W(DISP_W), .RIDX_W(RIDX_W), .RIDX_LSB(11)
  ) u_dec (
    .insn(in_insn), .pc(in_pc), .rd_data(rd_data),
    .kind(kind), .rd_idx(rd_idx), .tgt(tgt)
  );

  npc_resolve u_res (
    .kind(kind), .cc(cc_flag), .is_xfer(is_xfer), .is_call(is_call),
    .take(take), .hinted(hinted), .annul(annul)
  );

  npc_seq #(
    .XLEN(XLEN), .START_ADDR(XLEN'(START_ADDR))
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire), .pc(in_pc),
    .is_xfer(is_xfer), .take(take), .tgt(tgt),
    .npc(out_npc), .slot_q(slot_q), .pend_tgt(pend_tgt), .fetch_q(fetch_addr)
  );

  assign out_annul = in_valid && !slot_q && annul;
  assign rf_we     = fire && !slot_q && is_call;
  assign rf_idx    = RIDX_W'(LINK_REG);
  assign rf_data   = in_pc + XLEN'(8);

  p_link_arms_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> slot_q);

  p_annul_hint_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_annul |-> (hinted && !take));

  p_slot_plain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && slot_q) |-> (!rf_we && !out_annul));

  p_ind_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !slot_q && kind == K_IND) |=> pend_tgt[1:0] == 2'b00);

  p_handshake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready == out_ready) && (out_valid == in_valid));
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
  localparam logic [31:0] START = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [31:0] in_insn = '0;
  logic        cc_flag = 1'b0;
  logic [4:0]  rd_idx;
  logic [31:0] rd_data;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_npc;
  logic        out_annul;
  logic        rf_we;
  logic [4:0]  rf_idx;
  logic [31:0] rf_data;
  logic [31:0] fetch_addr;

  logic [31:0] regs [32];
  assign rd_data = regs[rd_idx];

  always #4 clk = ~clk;

  npc_unit #(.START_ADDR(START)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_insn(in_insn), .cc_flag(cc_flag), .rd_idx(rd_idx),
    .rd_data(rd_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_npc(out_npc), .out_annul(out_annul), .rf_we(rf_we), .rf_idx(rf_idx),
    .rf_data(rf_data), .fetch_addr(fetch_addr)
  );

  int checks = 0;
  int fails = 0;

  logic        m_slot = 1'b0;
  logic        m_take = 1'b0;
  logic [31:0] m_tgt = '0;
  logic [31:0] m_fetch = START;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_ctrl(input logic [5:0] op);
    return op == 6'h10 || (op >= 6'h1A && op <= 6'h1F);
  endfunction

  function automatic bit taken_of(input logic [5:0] op, input logic cc);
    case (op)
      6'h1C, 6'h1D: return cc;
      6'h1E, 6'h1F: return !cc;
      default:      return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] target_of(input logic [31:0] pc, input logic [31:0] insn);
    if (insn[31:26] == 6'h10) return {regs[insn[15:11]][31:2], 2'b00};
    return pc + 32'd4 + {{4{insn[25]}}, insn[25:0], 2'b00};
  endfunction

  task automatic beat(input logic [31:0] insn, input logic cc, input logic rdy);
    logic [5:0]  op;
    bit          ctl, tk, call;
    logic [31:0] e_npc, pc;
    @(negedge clk);
    pc = m_fetch;
    in_valid = 1'b1; out_ready = rdy; in_pc = pc; in_insn = insn; cc_flag = cc;
    #1;
    op   = insn[31:26];
    ctl  = !m_slot && is_ctrl(op);
    tk   = ctl && taken_of(op, cc);
    call = ctl && op == 6'h1B;
    e_npc = (m_slot && m_take) ? m_tgt : pc + 32'd4;
    chk(in_ready == rdy && out_valid, "R9 handshake", {31'd0, in_ready}, {31'd0, rdy});
    chk(out_npc == e_npc, m_slot ? "R3/R5/R8 slot npc" : "R2/R3 npc", out_npc, e_npc);
    chk(out_annul == (ctl && (op == 6'h1D || op == 6'h1F) && !tk), "R6 annul",
        {31'd0, out_annul}, {31'd0, (ctl && (op == 6'h1D || op == 6'h1F) && !tk)});
    chk(rf_we == (call && rdy), "R4/R8 rf_we", {31'd0, rf_we}, {31'd0, call && rdy});
    if (call && rdy)
      chk(rf_idx == 5'd1 && rf_data == pc + 32'd8, "R4 link", rf_data, pc + 32'd8);
    if (op == 6'h10)
      chk(rd_idx == insn[15:11], "R7 rd_idx", {27'd0, rd_idx}, {27'd0, insn[15:11]});
    @(posedge clk);
    if (rdy) begin
      if (ctl) m_tgt = target_of(pc, insn);
      m_take  = tk;
      m_slot  = ctl;
      m_fetch = e_npc;
    end
    #1;
    chk(fetch_addr == m_fetch, rdy ? "R10 fetch" : "R9 stall hold", fetch_addr, m_fetch);
    in_valid = 1'b0;
  endtask

  function automatic logic [31:0] mk(input logic [5:0] op, input logic [25:0] f);
    return {op, f};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [5:0] ctl_ops [8];
    void'($urandom(32'd860));
    for (int i = 0; i < 32; i++) regs[i] = $urandom();
    regs[7] = 32'h0000_4003;
    ctl_ops = '{6'h10, 6'h1A, 6'h1B, 6'h1C, 6'h1D, 6'h1E, 6'h1F, 6'h1A};

    repeat (3) @(posedge clk);
    #1;
    chk(fetch_addr == START, "R1 reset fetch", fetch_addr, START);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(fetch_addr == START, "R1 after release", fetch_addr, START);

    beat(mk(6'h20, 26'h123), 1'b0, 1'b1);            // R2 plain
    beat(mk(6'h1A, 26'h10), 1'b0, 1'b1);             // R3 jump forward
    beat(mk(6'h00, 26'h0), 1'b0, 1'b1);              // delay slot -> target
    beat(mk(6'h1A, 26'h3FF_FFFF), 1'b0, 1'b1);       // R3 displacement -1
    beat(mk(6'h1A, 26'h5), 1'b0, 1'b1);              // R8 jump inside slot ignored
    beat(mk(6'h1C, 26'h20), 1'b0, 1'b1);             // R5 bset not taken
    beat(mk(6'h20, 26'h0), 1'b0, 1'b1);
    beat(mk(6'h1D, 26'h20), 1'b0, 1'b1);             // R6 hinted not taken annuls
    beat(mk(6'h20, 26'h0), 1'b0, 1'b1);
    beat(mk(6'h1F, 26'h40), 1'b0, 1'b1);             // R5 hinted bclr taken
    beat(mk(6'h20, 26'h0), 1'b0, 1'b0);              // R9 stall in slot
    beat(mk(6'h20, 26'h0), 1'b0, 1'b1);
    beat(mk(6'h1B, 26'h200_0000), 1'b1, 1'b1);       // R4 call, most negative disp
    beat(mk(6'h1B, 26'h8), 1'b1, 1'b1);              // R8 call in slot: no write
    beat(mk(6'h10, {10'h0, 5'd7, 11'h0}), 1'b0, 1'b1); // R7 indirect, low bits cleared
    beat(mk(6'h20, 26'h0), 1'b0, 1'b1);
    beat(mk(6'h1E, 26'h1FF_FFFF), 1'b1, 1'b1);       // R5 bclr not taken, max positive disp
    beat(mk(6'h1E, 26'h4), 1'b0, 1'b1);              // R8 in slot
    beat(mk(6'h20, 26'h0), 1'b0, 1'b1);

    for (int n = 0; n < 600; n++) begin
      logic [5:0]  op;
      logic [31:0] r;
      r = $urandom();
      if (r[2:0] < 3'd5) op = ctl_ops[r[5:3]];
      else begin
        op = r[31:26];
        if (is_ctrl(op)) op = 6'h21;
      end
      beat(mk(op, 26'($urandom())), r[8], r[11:9] != 3'd0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule